// File: doc/BRIEF.md
# I2C Master Write Transmitter

This block is the transmit half of an I2C bus master. Software drives it through a small register interface. A control word holds an interrupt enable, a transmit-interrupt enable, a start request, a stop request and a flush strobe. A data holding register accepts the next byte. Three status outputs report the holding register empty flag, the last acknowledge result and a sticky not-acknowledge flag. One interrupt line tells software when it can write the next byte or when the slave has refused a byte.

The holding register and the shift register are separate. The holding register is reported empty as soon as the first bit of the byte just moved into the shifter has been clocked out, so software has almost a full byte time to supply the next byte. Software builds the 10-bit address sequence itself. The first byte is `11110`, then address bits 9..8, then a 0 for write. The second byte is address bits 7..0, shifted like any data byte. SCL comes from a parameterised quarter-period divider. SDA is an open-drain enable plus a sampled input, so an external slave can pull the line low.

When any byte is not acknowledged, the engine parks the bus with SCL low and shifts nothing more. It stays there until software asks for STOP, normally together with FLUSH.

Top module: `i2c_wr_master`

## Requirements
- R1: After reset, SCL is high, SDA is released, the empty flag is 1, the acknowledge and not-acknowledge flags are 0, all control bits read 0 and the interrupt is low. Whenever the engine is idle, the bus stays in this released state.
- R2: The control word bit positions are: bit 0 interrupt enable, bit 1 transmit-interrupt enable, bit 2 start request, bit 3 stop request, bit 4 flush. The flush bit acts on write and always reads back as 0.
- R3: The interrupt is high exactly when the interrupt enable is set and either the empty flag and the transmit-interrupt enable are both set, or the not-acknowledge flag is set. With the interrupt enable clear, the interrupt stays low.
- R4: A data write is accepted only while the empty flag is 1, and accepting it clears the flag. A data write while the flag is 0 is discarded and does not change the byte that goes onto the bus.
- R5: With the engine idle, a byte loaded and the start request set, the engine makes SDA fall while SCL is high. It then shifts the byte out MSB first, one bit per SCL pulse, and the start request bit clears by itself.
- R6: The empty flag returns to 1 at the end of the SCL high time of the first bit of the byte that was moved into the shifter, not when the byte is loaded.
- R7: SDA changes only while SCL is low. The two exceptions are the START edge and the STOP edge, which happen while SCL is high.
- R8: In the ninth SCL high period of each byte SDA is released and sampled. Low means acknowledge and sets the acknowledge flag. If a next byte is waiting, it follows with no gap.
- R9: On a not-acknowledge of any byte, the not-acknowledge flag is set, the acknowledge flag is cleared and the interrupt is raised. SCL is then held low with no further clock pulses until a stop is requested.
- R10: Writing the flush bit discards any byte waiting in the holding register and sets the empty flag. After a not-acknowledge, a stop request produces a STOP condition and then clears both the stop request bit and the not-acknowledge flag.
- R11: A stop request during a normal transfer takes effect only after the current byte and its acknowledge bit, and only when the holding register is empty. The engine then issues STOP and clears the stop request bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_we_i | input | 1 | Write strobe for the control word |
| ctrl_wdata_i | input | 5 | Control word to write (bit map in R2) |
| data_we_i | input | 1 | Write strobe for the holding register |
| data_wdata_i | input | 8 | Byte to write into the holding register |
| ctrl_o | output | 5 | Control word readback |
| tdre_o | output | 1 | Holding register empty flag |
| ack_o | output | 1 | Last acknowledge bit was low |
| nacki_o | output | 1 | Sticky not-acknowledge flag |
| irq_o | output | 1 | Interrupt request |
| scl_o | output | 1 | Serial clock |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| sda_i | input | 1 | Sampled SDA bus level |

## Verification
The assertions check on every cycle the rules that hold in every state: SDA edges while SCL is high occur only at START and STOP, the bus is released whenever the engine is idle, SCL stays low and the engine stays put after a not-acknowledge, a START needs a loaded byte, a STOP in normal flow needs an empty holding register, a blocked data write leaves the held byte alone, and flush restores the empty flag. Only the bench's slave model can show the serial content: the exact byte sequence that reaches the slave, MSB-first order, the bit at which the empty flag returns, how a refused byte at each position of a 10-bit address write cuts the transfer short, and that a discarded write never reaches the bus.

// File: rtl/i2c_wr_pkg.sv
package i2c_wr_pkg;
  localparam int unsigned CTRL_W  = 5;
  localparam int unsigned C_IEN   = 0;
  localparam int unsigned C_TXI   = 1;
  localparam int unsigned C_START = 2;
  localparam int unsigned C_STOP  = 3;
  localparam int unsigned C_FLUSH = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_BIT,
    ST_WAIT,
    ST_HOLD,
    ST_STOP
  } eng_st_e;
endpackage

// File: rtl/i2c_wr_tick.sv
module i2c_wr_tick #(
  parameter int unsigned QDIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned TW = (QDIV > 1) ? $clog2(QDIV) : 1;

  generate
    if (QDIV <= 1) begin : g_every
      assign tick_o = 1'b1;
    end else begin : g_count
      logic [TW-1:0] cnt_q;
      assign tick_o = (cnt_q == TW'(QDIV - 1));
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     cnt_q <= '0;
        else if (tick_o) cnt_q <= '0;
        else             cnt_q <= cnt_q + TW'(1);
      end
    end
  endgenerate
endmodule

// File: rtl/i2c_wr_regs.sv
module i2c_wr_regs
  import i2c_wr_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_we_i,
  input  logic [CTRL_W-1:0] ctrl_wdata_i,
  input  logic              data_we_i,
  input  logic [DW-1:0]     data_wdata_i,
  input  logic              start_taken_i,
  input  logic              first_bit_i,
  input  logic              ack_p_i,
  input  logic              nack_p_i,
  input  logic              stop_done_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic [DW-1:0]     data_o,
  output logic              tdre_o,
  output logic              ack_o,
  output logic              nacki_o,
  output logic              irq_o
);
  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic [DW-1:0]     data_q;
  logic              tdre_q, ack_q, nacki_q;
  logic              flush_w;

  assign flush_w = ctrl_we_i & ctrl_wdata_i[C_FLUSH];

  always_comb begin
    ctrl_d = ctrl_we_i ? ctrl_wdata_i : ctrl_q;
    if (start_taken_i) ctrl_d[C_START] = 1'b0;
    if (stop_done_i)   ctrl_d[C_STOP]  = 1'b0;
    ctrl_d[C_FLUSH] = 1'b0;  // strobe only
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      data_q  <= '0;
      tdre_q  <= 1'b1;
      ack_q   <= 1'b0;
      nacki_q <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      if (flush_w || first_bit_i) tdre_q <= 1'b1;
      else if (data_we_i && tdre_q) tdre_q <= 1'b0;
      if (data_we_i && tdre_q) data_q <= data_wdata_i;
      if (ack_p_i)       ack_q <= 1'b1;
      else if (nack_p_i) ack_q <= 1'b0;
      if (nack_p_i)         nacki_q <= 1'b1;
      else if (stop_done_i) nacki_q <= 1'b0;
    end
  end

  assign ctrl_o  = ctrl_q;
  assign data_o  = data_q;
  assign tdre_o  = tdre_q;
  assign ack_o   = ack_q;
  assign nacki_o = nacki_q;
  assign irq_o   = ctrl_q[C_IEN] & ((ctrl_q[C_TXI] & tdre_q) | nacki_q);

  AST_DATA_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_we_i && !tdre_q) |=> $stable(data_q)); // R4
  AST_NACK_ACK_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nacki_q |-> !ack_q); // R9
  AST_FLUSH_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_w |=> tdre_q); // R10
  AST_NACKI_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(nacki_q) |-> $past(stop_done_i)); // R10
endmodule

// File: rtl/i2c_wr_engine.sv
module i2c_wr_engine
  import i2c_wr_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          go_i,
  input  logic          stop_req_i,
  input  logic          data_valid_i,
  input  logic [DW-1:0] data_i,
  input  logic          sda_i,
  output logic          scl_o,
  output logic          sda_oe_o,
  output logic          start_taken_o,
  output logic          first_bit_o,
  output logic          ack_p_o,
  output logic          nack_p_o,
  output logic          stop_done_o
);
  localparam int unsigned   CW       = $clog2(DW + 1);
  localparam logic [CW-1:0] ACK_SLOT = CW'(DW);

  eng_st_e       st_q;
  logic [1:0]    q_q;
  logic [CW-1:0] bit_q;
  logic [DW-1:0] sh_q;
  logic          smp_q, scl_q, sda_oe_q;
  logic          end_bit, end_ack;

  assign end_bit       = tick_i && (st_q == ST_BIT) && (q_q == 2'd3);
  assign end_ack       = end_bit && (bit_q == ACK_SLOT);
  assign start_taken_o = tick_i && (st_q == ST_IDLE) && go_i && data_valid_i;
  assign first_bit_o   = end_bit && (bit_q == '0);
  assign ack_p_o       = end_ack && !smp_q;
  assign nack_p_o      = end_ack && smp_q;
  assign stop_done_o   = tick_i && (st_q == ST_STOP) && (q_q == 2'd3);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      q_q      <= '0;
      bit_q    <= '0;
      sh_q     <= '0;
      smp_q    <= 1'b1;
      scl_q    <= 1'b1;
      sda_oe_q <= 1'b0;
    end else if (tick_i) begin
      unique case (st_q)
        ST_IDLE: begin
          q_q      <= '0;
          scl_q    <= 1'b1;
          sda_oe_q <= 1'b0;
          if (go_i && data_valid_i) st_q <= ST_START;
        end
        ST_START: begin
          q_q <= q_q + 2'd1;
          if (q_q == 2'd0) sda_oe_q <= 1'b1;  // SDA falls, SCL high
          if (q_q == 2'd3) begin
            scl_q <= 1'b0;
            st_q  <= ST_BIT;
            bit_q <= '0;
            sh_q  <= data_i;
          end
        end
        ST_BIT: begin
          q_q <= q_q + 2'd1;
          unique case (q_q)
            2'd0: sda_oe_q <= (bit_q != ACK_SLOT) ? !sh_q[DW-1] : 1'b0;
            2'd1: scl_q <= 1'b1;
            2'd2: smp_q <= sda_i;
            default: begin
              scl_q <= 1'b0;
              if (bit_q != ACK_SLOT) begin
                sh_q  <= {sh_q[DW-2:0], 1'b0};
                bit_q <= bit_q + CW'(1);
              end else if (smp_q) begin
                st_q <= ST_HOLD;
              end else if (data_valid_i) begin
                sh_q  <= data_i;
                bit_q <= '0;
              end else if (stop_req_i) begin
                st_q <= ST_STOP;
              end else begin
                st_q <= ST_WAIT;
              end
            end
          endcase
        end
        ST_WAIT: begin
          q_q <= '0;
          if (data_valid_i) begin
            st_q  <= ST_BIT;
            sh_q  <= data_i;
            bit_q <= '0;
          end else if (stop_req_i) begin
            st_q <= ST_STOP;
          end
        end
        ST_HOLD: begin
          q_q <= '0;
          if (stop_req_i) st_q <= ST_STOP;
        end
        ST_STOP: begin
          q_q <= q_q + 2'd1;
          if (q_q == 2'd0) sda_oe_q <= 1'b1;
          if (q_q == 2'd1) scl_q <= 1'b1;
          if (q_q == 2'd3) begin
            sda_oe_q <= 1'b0;  // SDA rises, SCL high
            st_q     <= ST_IDLE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign scl_o    = scl_q;
  assign sda_oe_o = sda_oe_q;

  AST_SDA_EDGE_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_q && $past(scl_q) && (sda_oe_q != $past(sda_oe_q)))
      |-> ($past(st_q) == ST_START || $past(st_q) == ST_STOP)); // R7
  AST_IDLE_BUS_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE) |-> (scl_q && !sda_oe_q)); // R1
  AST_HOLD_NO_CLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_HOLD) |-> !scl_q); // R9
  AST_HOLD_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_HOLD) |=> (st_q == ST_HOLD || st_q == ST_STOP)); // R9
  AST_START_NEEDS_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_START && $past(st_q) == ST_IDLE) |-> $past(go_i && data_valid_i)); // R5
  AST_STOP_WHEN_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_STOP && $past(st_q) != ST_STOP && $past(st_q) != ST_HOLD)
      |-> $past(stop_req_i && !data_valid_i)); // R11
endmodule

// File: rtl/i2c_wr_master.sv
module i2c_wr_master
  import i2c_wr_pkg::*;
#(
  parameter int unsigned QDIV = 4,
  parameter int unsigned DW   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_we_i,
  input  logic [CTRL_W-1:0] ctrl_wdata_i,
  input  logic              data_we_i,
  input  logic [DW-1:0]     data_wdata_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic              tdre_o,
  output logic              ack_o,
  output logic              nacki_o,
  output logic              irq_o,
  output logic              scl_o,
  output logic              sda_oe_o,
  input  logic              sda_i
);
  logic          tick;
  logic [DW-1:0] hold_data;
  logic          start_taken, first_bit, ack_p, nack_p, stop_done;

  i2c_wr_tick #(.QDIV(QDIV)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (tick)
  );

  i2c_wr_regs #(.DW(DW)) u_regs (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .ctrl_we_i     (ctrl_we_i),
    .ctrl_wdata_i  (ctrl_wdata_i),
    .data_we_i     (data_we_i),
    .data_wdata_i  (data_wdata_i),
    .start_taken_i (start_taken),
    .first_bit_i   (first_bit),
    .ack_p_i       (ack_p),
    .nack_p_i      (nack_p),
    .stop_done_i   (stop_done),
    .ctrl_o        (ctrl_o),
    .data_o        (hold_data),
    .tdre_o        (tdre_o),
    .ack_o         (ack_o),
    .nacki_o       (nacki_o),
    .irq_o         (irq_o)
  );

  i2c_wr_engine #(.DW(DW)) u_engine (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .tick_i        (tick),
    .go_i          (ctrl_o[C_START]),
    .stop_req_i    (ctrl_o[C_STOP]),
    .data_valid_i  (!tdre_o),
    .data_i        (hold_data),
    .sda_i         (sda_i),
    .scl_o         (scl_o),
    .sda_oe_o      (sda_oe_o),
    .start_taken_o (start_taken),
    .first_bit_o   (first_bit),
    .ack_p_o       (ack_p),
    .nack_p_o      (nack_p),
    .stop_done_o   (stop_done)
  );
endmodule

// File: tb/i2c_wr_master_bench.sv
module i2c_wr_master_bench;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       ctrl_we = 1'b0;
  logic [4:0] ctrl_wdata = '0;
  logic       data_we = 1'b0;
  logic [7:0] data_wdata = '0;
  logic [4:0] ctrl_o;
  logic       tdre_o, ack_o, nacki_o, irq_o, scl_o, sda_oe_o, sda_i;

  always #5 clk = ~clk;

  i2c_wr_master u_i2c_wr_master (
    .clk_i(clk), .rst_ni(rst_ni), .ctrl_we_i(ctrl_we), .ctrl_wdata_i(ctrl_wdata),
    .data_we_i(data_we), .data_wdata_i(data_wdata), .ctrl_o(ctrl_o),
    .tdre_o(tdre_o), .ack_o(ack_o), .nacki_o(nacki_o), .irq_o(irq_o),
    .scl_o(scl_o), .sda_oe_o(sda_oe_o), .sda_i(sda_i)
  );

  // slave model
  logic       pull = 1'b0;
  logic       prev_scl = 1'b1, prev_bus = 1'b1, prev_tdre = 1'b1, prev_nacki = 1'b0;
  logic [7:0] s_byte = '0;
  logic [7:0] log_q [64];
  int         s_cnt = 0, s_idx = 0, log_n = 0, start_n = 0, stop_n = 0, nack_n = 0;
  int         rise_cnt = -1;
  int         nack_at = 0;

  assign sda_i = ~(sda_oe_o | pull);

  always @(negedge clk) begin
    logic cur;
    cur = ~(sda_oe_o | pull);
    if (!rst_ni) begin
      s_cnt = 0; s_idx = 0; pull = 1'b0; prev_scl = 1'b1; prev_bus = 1'b1;
    end else begin
      if (scl_o && prev_scl && prev_bus && !cur) begin
        start_n++; s_cnt = 0; s_idx = 0;
      end else if (scl_o && prev_scl && !prev_bus && cur) begin
        stop_n++;
      end else if (scl_o && !prev_scl) begin
        if (s_cnt < 8) s_byte = {s_byte[6:0], cur};
        s_cnt++;
      end else if (!scl_o && prev_scl) begin
        if (s_cnt == 8) pull = (nack_at != s_idx + 1);
        else if (s_cnt == 9) begin
          pull = 1'b0;
          if (log_n < 64) log_q[log_n] = s_byte;
          log_n++; s_idx++; s_cnt = 0;
        end
      end
      if (tdre_o && !prev_tdre) rise_cnt = s_cnt;
      if (nacki_o && !prev_nacki) nack_n++;
      prev_scl = scl_o;
      prev_bus = ~(sda_oe_o | pull);
    end
    prev_tdre  = tdre_o;
    prev_nacki = nacki_o;
  end

  int checks = 0, fails = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_ctrl(input logic [4:0] v);
    @(negedge clk); ctrl_we = 1'b1; ctrl_wdata = v;
    @(negedge clk); ctrl_we = 1'b0;
  endtask

  task automatic wr_data(input logic [7:0] v);
    @(negedge clk); data_we = 1'b1; data_wdata = v;
    @(negedge clk); data_we = 1'b0;
  endtask

  // {addr[9:0], d0, d1, nack position (1-based byte, 0 = none)}
  localparam logic [28:0] VEC [6] = '{
    {10'h3A5, 8'h12, 8'h34, 3'd0},
    {10'h000, 8'hFF, 8'h00, 3'd0},
    {10'h2C1, 8'hA5, 8'h5A, 3'd1},
    {10'h155, 8'h81, 8'h7E, 3'd3},
    {10'h0F0, 8'h00, 8'hC3, 3'd4},
    {10'h3FF, 8'h69, 8'h96, 3'd2}
  };

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);

    foreach (VEC[v]) begin
      logic [9:0] a;
      logic [7:0] b [4];
      int na, exp_n, base, st0, sp0, nk0;
      a  = VEC[v][28:19];
      b[0] = {5'b11110, a[9:8], 1'b0};
      b[1] = a[7:0];
      b[2] = VEC[v][18:11];
      b[3] = VEC[v][10:3];
      na = int'(VEC[v][2:0]);
      nack_at = na;
      exp_n = (na == 0) ? 4 : na;
      base = log_n; st0 = start_n; sp0 = stop_n; nk0 = nack_n;

      wr_ctrl(5'b00011);
      check(irq_o == 1'b1, "R3 tx irq when empty", irq_o, 1);
      wr_data(b[0]);
      wr_ctrl(5'b00111);
      for (int i = 1; i < 4; i++) begin
        while (!(tdre_o || nacki_o)) @(negedge clk);
        if (nacki_o) break;
        wr_data(b[i]);
      end
      while (!(tdre_o || nacki_o)) @(negedge clk);
      if (nacki_o) begin
        check(irq_o == 1'b1 && ack_o == 1'b0, "R9 nack irq, ack cleared", {irq_o, ack_o}, 2);
        repeat (40) @(negedge clk);
        check(scl_o == 1'b0, "R9 scl parked low", scl_o, 0);
        wr_ctrl(5'b11001);
      end else begin
        wr_ctrl(5'b01001);
      end
      while (ctrl_o[3]) @(negedge clk);
      repeat (4) @(negedge clk);

      check(log_n - base == exp_n, "R8 R9 byte count", log_n - base, exp_n);
      for (int i = 0; i < exp_n; i++)
        check(log_q[base + i] == b[i], "R5 R8 byte content", log_q[base + i], b[i]);
      check(start_n - st0 == 1, "R5 one start", start_n - st0, 1);
      check(stop_n - sp0 == 1, "R10 R11 one stop", stop_n - sp0, 1);
      check((nack_n - nk0) == ((na != 0) ? 1 : 0), "R9 nack flagged", nack_n - nk0, (na != 0) ? 1 : 0);
      check(nacki_o == 1'b0 && ctrl_o[3] == 1'b0, "R10 stop and nack flags cleared", {nacki_o, ctrl_o[3]}, 0);
      check(tdre_o == 1'b1, "R10 empty after flush/stop", tdre_o, 1);
      check(ack_o == (na == 0), "R8 ack flag", ack_o, (na == 0) ? 1 : 0);
      check(scl_o && !sda_oe_o, "R11 bus released", {scl_o, sda_oe_o}, 2);
    end

    // directed: reset state
    nack_at = 0;
    rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check(scl_o == 1'b1 && sda_oe_o == 1'b0, "R1 bus idle", {scl_o, sda_oe_o}, 2);
    check(tdre_o == 1'b1 && ack_o == 1'b0 && nacki_o == 1'b0, "R1 status", {tdre_o, ack_o, nacki_o}, 4);
    check(ctrl_o == 5'b0 && irq_o == 1'b0, "R1 ctrl and irq", {ctrl_o, irq_o}, 0);

    // directed: flush self-clears, irq gated by enable
    wr_ctrl(5'b10011);
    check(ctrl_o == 5'b00011, "R2 flush reads 0", ctrl_o, 5'b00011);
    wr_ctrl(5'b00010);
    check(irq_o == 1'b0, "R3 irq masked without enable", irq_o, 0);

    // directed: blocked write, start, early empty, stop after single byte
    begin
      int base, sp0;
      base = log_n; sp0 = stop_n;
      wr_data(8'hF0);
      check(tdre_o == 1'b0, "R4 write clears empty", tdre_o, 0);
      wr_data(8'h55);
      wr_ctrl(5'b00100);
      while (!tdre_o) @(negedge clk);
      @(negedge clk);
      check(rise_cnt == 1, "R6 empty after first bit", rise_cnt, 1);
      check(ctrl_o[2] == 1'b0, "R5 start self-clears", ctrl_o[2], 0);
      wr_ctrl(5'b01000);
      check(stop_n == sp0, "R11 stop waits for byte end", stop_n - sp0, 0);
      while (ctrl_o[3]) @(negedge clk);
      repeat (4) @(negedge clk);
      check(log_n - base == 1, "R11 single byte sent", log_n - base, 1);
      check(log_q[base] == 8'hF0, "R4 discarded write not sent", log_q[base], 8'hF0);
      check(stop_n - sp0 == 1 && ack_o == 1'b1, "R11 R8 stop and ack", stop_n - sp0, 1);
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule